// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block collects interrupt requests from a set of primary lines, one per priority level, and from a second bank of extended sources. It presents one level code to the processor's trap sequencer. The code is the highest enabled, pending level, and it is presented only when that level is above the processor interrupt level (PIL) and traps are enabled. Level 0 means that nothing is requested. The top level is non-maskable: the PIL cannot hold it back, although the trap-enable input still can.

All extended sources share one programmable primary level. When the sequencer acknowledges that level, the controller records which extended source is being serviced and clears only that source's pending bit. Software reads the recorded identity from a register.

A small register port reads the pending bits and clears them, sets the per-source enables, and chooses the shared extended level. A rising edge on a request line sets its pending bit. The bit is cleared by an acknowledge from the trap sequencer or by a software clear.

Top module: `pilc_top`

## Requirements
- R1: After reset, all pending bits and enable bits are 0, the extended level register holds XLVL_RST (default 10), the extended ID register reads 0, and `irl_o` is 0.
- R2: A rising edge on `prim_req_i[k]` (k from 1 to 15) sets pending bit k. This is bit k of the PEND register at address 0. A line held high sets its bit only once. `prim_req_i[0]` has no effect.
- R3: `irl_o` carries the highest level whose pending and enable bits are both 1. Enable bit k is bit k of the ENABLE register at address 2. That level is presented only when it is greater than `pil_i`; otherwise `irl_o` is 0.
- R4: Level 15 is presented whatever the value of `pil_i`. While `et_i` is 0, `irl_o` is 0. With `pil_i` at 15, levels 1 to 14 are never presented.
- R5: A rising edge on `ext_req_i[i]` sets PEND bit 16+i. If ENABLE bit 16+i is also 1, the source makes the extended level pending. A pending source whose enable is 0 raises no level.
- R6: An acknowledge (`ack_i`=1) of level L clears primary pending bit L. If L equals the extended level and an enabled extended source is pending, the ID register (address 4, bits [4:0]) takes 16 plus the index of the highest such source, and that source's pending bit is cleared.
- R7: The ID register keeps its value until the next acknowledge of the extended level that finds an enabled extended source pending.
- R8: Writing 1s to address 1 clears the matching PEND bits, and address 1 reads as 0. Writes to PEND and ID are ignored. Unmapped addresses read as 0.
- R9: Address 3 bits [3:0] select the extended level. A write of 0 or 15 is ignored, so the level always stays within 1 to 14.
- R10: When a new request edge and a clear (software or acknowledge) reach the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prim_req_i | input | 16 | Primary request lines; bit k requests level k, and bit 0 is unused |
| ext_req_i | input | 16 | Extended request lines for sources 16 to 31 |
| pil_i | input | 4 | Current processor interrupt level |
| et_i | input | 1 | Trap enable; 0 blocks every level |
| ack_i | input | 1 | Trap sequencer acknowledge strobe |
| ack_lvl_i | input | 4 | Level being acknowledged |
| irl_o | output | 4 | Requested interrupt level, 0 when none |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The selection logic is driven with a single pending level, with two levels pending at once, and with a higher level masked by its enable bit. Together these separate "highest wins" from "first wins" and from ignoring the enables. PIL values are placed exactly at the pending level and one below it, which catches an off-by-one in the greater-than comparison. Level 15 is tested against a PIL of 15, and level 14 against the same PIL, to separate the non-maskable level from ordinary ones. The extended bank is driven with two sources pending together and acknowledged twice, which shows that the ID register captures the highest source and then holds. Unrelated acknowledges and a disabled source show that the ID register does not move when it should not.

// File: rtl/pilc_pkg.sv
package pilc_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_PEND = 3'd0,
      RA_CLR  = 3'd1,
      RA_EN   = 3'd2,
      RA_XLVL = 3'd3,
      RA_XID  = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/pilc_edge.sv
module pilc_edge #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] req_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] req_q;

   for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) req_q[g] <= 1'b0;
         else         req_q[g] <= req_i[g];
      end
      assign rise_o[g] = req_i[g] & ~req_q[g];
   end
endmodule

// File: rtl/pilc_pend.sv
module pilc_pend #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);
   // a fresh edge outranks a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o <= '0;
      else         pend_o <= (pend_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/pilc_prio.sv
module pilc_prio #(
   parameter int unsigned W     = 16,
   parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   // upward scan: the last hit, the highest index, wins
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pilc_top.sv
module pilc_top
   import pilc_pkg::*;
#(
   parameter int unsigned NUM_LVL  = 16,
   parameter int unsigned NUM_EXT  = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned XLVL_RST = 10,
   localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_LVL-1:0] prim_req_i,
   input  logic [NUM_EXT-1:0] ext_req_i,
   input  logic [LVL_W-1:0]   pil_i,
   input  logic               et_i,
   input  logic               ack_i,
   input  logic [LVL_W-1:0]   ack_lvl_i,
   output logic [LVL_W-1:0]   irl_o,
   input  logic               reg_wr_i,
   input  logic [REG_AW-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o
);
   localparam int unsigned SRC_W  = NUM_LVL + NUM_EXT;
   localparam int unsigned ID_W   = $clog2(SRC_W);
   localparam int unsigned XIDX_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;
   localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LVL - 1);

   if ((NUM_LVL < 4) || ((1 << LVL_W) != NUM_LVL)) begin : g_chk_lvl
      $error("NUM_LVL must be a power of two of at least 4");
   end
   if (NUM_EXT < 1) begin : g_chk_ext
      $error("NUM_EXT must be at least 1");
   end
   if (SRC_W > DATA_W) begin : g_chk_w
      $error("DATA_W too narrow for the pending map");
   end
   if ((XLVL_RST < 1) || (XLVL_RST > NUM_LVL - 2)) begin : g_chk_rst
      $error("XLVL_RST must be a maskable level");
   end

   logic [NUM_LVL-1:0] rise_p, set_p, clr_p, ack_clr_p, pend_p, en_p, lvl_act;
   logic [NUM_EXT-1:0] rise_x, clr_x, ack_clr_x, pend_x, en_x, x_act;
   logic [LVL_W-1:0]   xlvl_q, top_lvl;
   logic [ID_W-1:0]    xid_q;
   logic [XIDX_W-1:0]  x_idx;
   logic               x_any, top_any, ext_take, sw_clr, wr_en, wr_xlvl;

   // ---------------- edge capture ----------------
   pilc_edge #(.W(NUM_LVL)) u_edge_p (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(prim_req_i), .rise_o(rise_p));
   pilc_edge #(.W(NUM_EXT)) u_edge_x (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(ext_req_i), .rise_o(rise_x));

   assign set_p = {rise_p[NUM_LVL-1:1], 1'b0};

   // ---------------- register decode ----------------
   assign sw_clr  = reg_wr_i && (reg_addr_i == RA_CLR);
   assign wr_en   = reg_wr_i && (reg_addr_i == RA_EN);
   assign wr_xlvl = reg_wr_i && (reg_addr_i == RA_XLVL)
                    && (reg_wdata_i[LVL_W-1:0] != '0)
                    && (reg_wdata_i[LVL_W-1:0] != NMI_LVL);

   // ---------------- extended stage ----------------
   assign x_act = pend_x & en_x;

   pilc_prio #(.W(NUM_EXT), .IDX_W(XIDX_W)) u_prio_x (
      .vec_i(x_act), .any_o(x_any), .idx_o(x_idx));

   assign ext_take = ack_i && (ack_lvl_i == xlvl_q) && x_any;

   for (genvar g = 0; g < NUM_EXT; g++) begin : g_xack
      assign ack_clr_x[g] = ext_take && (x_idx == XIDX_W'(g));
   end
   for (genvar g = 0; g < NUM_LVL; g++) begin : g_pack
      assign ack_clr_p[g] = ack_i && (ack_lvl_i == LVL_W'(g));
   end

   assign clr_p = ack_clr_p | ({NUM_LVL{sw_clr}} & reg_wdata_i[NUM_LVL-1:0]);
   assign clr_x = ack_clr_x | ({NUM_EXT{sw_clr}} & reg_wdata_i[SRC_W-1:NUM_LVL]);

   pilc_pend #(.W(NUM_LVL)) u_pend_p (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_p), .clr_i(clr_p), .pend_o(pend_p));
   pilc_pend #(.W(NUM_EXT)) u_pend_x (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rise_x), .clr_i(clr_x), .pend_o(pend_x));

   // ---------------- level selection ----------------
   always_comb begin
      lvl_act    = pend_p & en_p;
      lvl_act[0] = 1'b0;
      for (int k = 1; k < NUM_LVL; k++) begin
         if (x_any && (xlvl_q == LVL_W'(k))) lvl_act[k] = 1'b1;
      end
   end

   pilc_prio #(.W(NUM_LVL), .IDX_W(LVL_W)) u_prio_l (
      .vec_i(lvl_act), .any_o(top_any), .idx_o(top_lvl));

   assign irl_o = (et_i && top_any && ((top_lvl == NMI_LVL) || (top_lvl > pil_i)))
                  ? top_lvl : '0;

   // ---------------- configuration and ID ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_p   <= '0;
         en_x   <= '0;
         xlvl_q <= LVL_W'(XLVL_RST);
         xid_q  <= '0;
      end else begin
         if (wr_en) begin
            en_p <= reg_wdata_i[NUM_LVL-1:0];
            en_x <= reg_wdata_i[SRC_W-1:NUM_LVL];
         end
         if (wr_xlvl) xlvl_q <= reg_wdata_i[LVL_W-1:0];
         if (ext_take) xid_q <= ID_W'(NUM_LVL) + ID_W'(x_idx);
      end
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         RA_PEND: reg_rdata_o[SRC_W-1:0] = {pend_x, pend_p};
         RA_EN:   reg_rdata_o[SRC_W-1:0] = {en_x, en_p};
         RA_XLVL: reg_rdata_o[LVL_W-1:0] = xlvl_q;
         RA_XID:  reg_rdata_o[ID_W-1:0]  = xid_q;
         default: reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/pilc_chk.sv
module pilc_chk #(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned LVL_W   = 4,
   parameter int unsigned ID_W    = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [LVL_W-1:0] pil_i,
   input logic             et_i,
   input logic             ack_i,
   input logic [LVL_W-1:0] ack_lvl_i,
   input logic [LVL_W-1:0] irl_o,
   input logic [LVL_W-1:0] xlvl_q,
   input logic [ID_W-1:0]  xid_q
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LVL - 1);

   AST_ABOVE_PIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irl_o != '0 && irl_o != TOP) |-> (irl_o > pil_i)); // R3
   AST_ET_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !et_i |-> (irl_o == '0)); // R4
   AST_PIL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pil_i == TOP) |-> (irl_o == '0 || irl_o == TOP)); // R4
   AST_ID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xid_q == '0) || (xid_q >= ID_W'(NUM_LVL))); // R6
   AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ack_i && ack_lvl_i == xlvl_q) |=> $stable(xid_q)); // R7
   AST_XLVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xlvl_q != '0) && (xlvl_q != TOP)); // R9
endmodule

bind pilc_top pilc_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .pil_i(pil_i), .et_i(et_i), .ack_i(ack_i),
   .ack_lvl_i(ack_lvl_i), .irl_o(irl_o), .xlvl_q(xlvl_q), .xid_q(xid_q));

// File: tb/pilc_top_bench.sv
module pilc_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] prim_req = '0;
   logic [15:0] ext_req = '0;
   logic [3:0]  pil = '0;
   logic        et = 1'b1;
   logic        ack = 1'b0;
   logic [3:0]  ack_lvl = '0;
   logic [3:0]  irl;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   int          n_chk = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   pilc_top u_pilc_top (
      .clk_i(clk), .rst_ni(rst_n), .prim_req_i(prim_req), .ext_req_i(ext_req),
      .pil_i(pil), .et_i(et), .ack_i(ack), .ack_lvl_i(ack_lvl), .irl_o(irl),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pulse_p(input logic [15:0] m);
      @(negedge clk);
      prim_req = m;
      @(negedge clk);
      prim_req = '0;
   endtask

   task automatic pulse_x(input logic [15:0] m);
      @(negedge clk);
      ext_req = m;
      @(negedge clk);
      ext_req = '0;
   endtask

   task automatic do_ack(input logic [3:0] l);
      @(negedge clk);
      ack = 1'b1; ack_lvl = l;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1 irl", {28'd0, irl}, 32'd0);
      rd(3'd0, v); check("R1 pend", v, 32'd0);
      rd(3'd2, v); check("R1 enable", v, 32'd0);
      rd(3'd3, v); check("R1 xlvl", v, 32'd10);
      rd(3'd4, v); check("R1 xid", v, 32'd0);
   endtask

   task automatic t_edge;
      logic [31:0] v;
      wr_reg(3'd2, 32'hFFFF_FFFF);
      @(negedge clk); prim_req = 16'h0008;
      @(negedge clk);
      rd(3'd0, v); check("R2 pend bit3", v, 32'h8);
      check("R3 single level", {28'd0, irl}, 32'd3);
      wr_reg(3'd1, 32'h8);
      @(negedge clk);
      rd(3'd0, v); check("R2 held line no reset", v, 32'h0);
      prim_req = '0;
      pulse_p(16'h0001);
      rd(3'd0, v); check("R2 bit0 ignored", v, 32'h0);
      check("R2 bit0 no irl", {28'd0, irl}, 32'd0);
   endtask

   task automatic t_prio;
      logic [31:0] v;
      pulse_p(16'h0220);
      check("R3 highest wins", {28'd0, irl}, 32'd9);
      pil = 4'd9; #1;
      check("R3 equal pil blocks", {28'd0, irl}, 32'd0);
      pil = 4'd8; #1;
      check("R3 pil below passes", {28'd0, irl}, 32'd9);
      pil = 4'd0;
      wr_reg(3'd2, 32'hFFFF_FDFF);
      check("R3 enable masks", {28'd0, irl}, 32'd5);
      wr_reg(3'd2, 32'hFFFF_FFFF);
      wr_reg(3'd1, 32'hFFFF_FFFF);
      rd(3'd0, v); check("R8 clear all", v, 32'h0);
   endtask

   task automatic t_nmi;
      pulse_p(16'h4000);
      pil = 4'd15; #1;
      check("R4 pil15 blocks 14", {28'd0, irl}, 32'd0);
      pulse_p(16'h8000);
      check("R4 level15 beats pil", {28'd0, irl}, 32'd15);
      et = 1'b0; #1;
      check("R4 et low blocks", {28'd0, irl}, 32'd0);
      et = 1'b1; pil = 4'd0;
      wr_reg(3'd1, 32'hFFFF_FFFF);
   endtask

   task automatic t_ext;
      logic [31:0] v;
      wr_reg(3'd3, 32'd6);
      pulse_x(16'h0084);
      rd(3'd0, v); check("R5 ext pend", v, 32'h0084_0000);
      check("R5 ext level", {28'd0, irl}, 32'd6);
      do_ack(4'd6);
      rd(3'd4, v); check("R6 id highest", v, 32'd23);
      rd(3'd0, v); check("R6 ext bit cleared", v, 32'h0004_0000);
      do_ack(4'd3);
      rd(3'd4, v); check("R7 id holds", v, 32'd23);
      do_ack(4'd6);
      rd(3'd4, v); check("R6 id next", v, 32'd18);
      wr_reg(3'd2, 32'h0000_FFFF);
      pulse_x(16'h0010);
      check("R5 disabled ext no irl", {28'd0, irl}, 32'd0);
      do_ack(4'd6);
      rd(3'd4, v); check("R7 id holds no source", v, 32'd18);
      rd(3'd0, v); check("R5 disabled stays pend", v, 32'h0010_0000);
      wr_reg(3'd1, 32'hFFFF_FFFF);
      wr_reg(3'd2, 32'hFFFF_FFFF);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr_reg(3'd3, 32'd0);
      rd(3'd3, v); check("R9 zero ignored", v, 32'd6);
      wr_reg(3'd3, 32'd15);
      rd(3'd3, v); check("R9 fifteen ignored", v, 32'd6);
      rd(3'd1, v); check("R8 clr reads 0", v, 32'd0);
      rd(3'd6, v); check("R8 unmapped 0", v, 32'd0);
      wr_reg(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); check("R8 pend write ignored", v, 32'd0);
      wr_reg(3'd4, 32'd31);
      rd(3'd4, v); check("R8 id write ignored", v, 32'd18);
   endtask

   task automatic t_race;
      logic [31:0] v;
      @(negedge clk);
      prim_req = 16'h0010; wr = 1'b1; addr = 3'd1; wdata = 32'h10;
      @(negedge clk);
      wr = 1'b0; prim_req = '0;
      rd(3'd0, v); check("R10 set beats clear", v, 32'h10);
      @(negedge clk);
      prim_req = 16'h0010; ack = 1'b1; ack_lvl = 4'd4;
      @(negedge clk);
      ack = 1'b0; prim_req = '0;
      wr_reg(3'd1, 32'h10);
      pulse_p(16'h0010);
      @(negedge clk);
      ack = 1'b1; ack_lvl = 4'd4; prim_req = 16'h0010;
      @(negedge clk);
      ack = 1'b0; prim_req = '0;
      rd(3'd0, v); check("R10 set beats ack", v, 32'h10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_prio();
      t_nmi();
      t_ext();
      t_regs();
      t_race();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule